// File: doc/BRIEF.md
# Cell Pixel Serializer

This block is the pixel stage of a character and bitmap video controller. Every character cell is eight clocks wide and is stepped by a 3-bit phase count supplied from outside. During a cell the block builds the address of the pattern byte to fetch. It loads that byte at the end of the cell and emits one 4-bit colour index per clock. In hi-res mode the byte leaves one bit per clock. In multicolor mode it leaves two bits every second clock, which gives pixels twice as wide.

Cell attributes are a screen byte plus a 4-bit colour-RAM nibble. They are captured from memory only on the first pixel row of each character row and kept in a line buffer with one entry per column. The later rows read them back from that buffer. Each cell's attributes are held stable while its eight pixels are shown. The pixel output is a fixed-rate video stream, so it has no valid/ready handshake and no back-pressure. All pins are plain control and data pins, sampled on the rising clock edge.

Top module: `cell_pixel_serializer`

## Requirements
- R1: While rst_n is low, the shift register and the held cell attributes clear. Until the first pattern load, pix_col therefore equals bg_col.
- R2: On a clock where phase is 7, the shift register loads pat_data. The following clock shows pattern bit 7, or bits 7:6 as a pair, first.
- R3: When mc_mode is 0, the register shifts left by one on every clock where phase is not 7. pix_col is the held colour nibble when the top bit is 1 and bg_col when it is 0.
- R4: When mc_mode is 1, the register shifts left by two only on clocks where phase is odd and not 7, and holds on even phases. Each bit pair therefore stays on pix_col for two clocks.
- R5: In multicolor mode the top pair selects the colour. 00 gives bg_col, 01 gives bits 7:4 of the held screen byte, 10 gives bits 3:0 of the held screen byte, and 11 gives the held colour nibble.
- R6: The attributes captured for a cell are copied into the held attributes at phase 7. They stay unchanged for the whole following cell.
- R7: When bmp_mode is 1, pat_addr is {pat_base[2], scr_pos[9:0], row_in_cell[2:0]}, with bit 13 as the MSB.
- R8: When bmp_mode is 0, pat_addr is {pat_base[2:0], code[7:0], row_in_cell[2:0]}. Here code is the screen byte captured for the current cell.
- R9: At phase 3 with row_in_cell equal to 0, {col_data, scr_data} is captured as the current cell's attributes and stored in line-buffer entry cell_idx. At phase 3 on any other row, the attributes come from entry cell_idx and scr_data/col_data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 3 | Position within the current 8-clock cell |
| bmp_mode | input | 1 | 1 selects bitmap addressing, 0 selects text addressing |
| mc_mode | input | 1 | 1 selects multicolor pairs, 0 selects hi-res bits |
| pat_base | input | 3 | Pattern base, upper address bits |
| scr_pos | input | 10 | Screen position pointer, used in bitmap mode |
| row_in_cell | input | 3 | Pixel row inside the character row |
| cell_idx | input | 6 | Column of the current cell, 0 to 39 |
| scr_data | input | 8 | Fetched screen byte, valid at phase 3 |
| col_data | input | 4 | Fetched colour-RAM nibble, valid at phase 3 |
| pat_addr | output | 14 | Pattern fetch address |
| pat_data | input | 8 | Fetched pattern byte, valid at phase 7 |
| bg_col | input | 4 | Background colour index |
| pix_col | output | 4 | Colour index of the current pixel |

## Verification
Assertions check on every cycle that the register loads at phase 7 and shifts or holds according to the mode and the phase parity. They also check that held attributes never move outside phase 7, that a first-row capture lands in the current attributes, and that a multicolor 00 pair shows the background. The bench's reference model shows what no single-cycle property can. It confirms the full colour of every pixel across whole rows in all four mode combinations. It confirms that attributes written on row 0 come back correctly on rows 1 to 7 while the fetched data on those rows is random noise, and it checks both address layouts.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int PHASE_W   = 3;
  localparam int COLOUR_W  = 4;
  localparam logic [PHASE_W-1:0] FETCH_PHASE = 3'd3;
  localparam logic [PHASE_W-1:0] LOAD_PHASE  = 3'd7;

  typedef logic [COLOUR_W-1:0] colour_t;

  typedef enum logic [1:0] {
    PAIR_BACK  = 2'b00,
    PAIR_SCR_H = 2'b01,
    PAIR_SCR_L = 2'b10,
    PAIR_CRAM  = 2'b11
  } pair_e;
endpackage

// File: rtl/cell_attr_buf.sv
module cell_attr_buf
  import cps_pkg::*;
#(
  parameter int N_COLS = 40,
  parameter int IDX_W  = 6,
  parameter int CODE_W = 8,
  parameter int ROW_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PHASE_W-1:0]  phase,
  input  logic [ROW_W-1:0]    row_in_cell,
  input  logic [IDX_W-1:0]    cell_idx,
  input  logic [CODE_W-1:0]   scr_data,
  input  colour_t             col_data,
  output logic [CODE_W-1:0]   cur_code,
  output logic [CODE_W-1:0]   held_scr,
  output colour_t             held_col
);
  localparam int ENT_W = CODE_W + COLOUR_W;

  logic [ENT_W-1:0] line_mem [N_COLS];
  logic [ENT_W-1:0] cur_ent;
  logic [ENT_W-1:0] held_ent;
  logic [ENT_W-1:0] fetched;
  logic [ENT_W-1:0] stored;
  logic             fetch_now;
  logic             first_row;
  logic             in_range;

  assign fetched   = {col_data, scr_data};
  assign fetch_now = (phase == FETCH_PHASE);
  assign first_row = (row_in_cell == '0);
  assign in_range  = (int'(cell_idx) < N_COLS);
  assign stored    = in_range ? line_mem[cell_idx] : '0;

  always_ff @(posedge clk) begin
    if (fetch_now && first_row && in_range) begin
      line_mem[cell_idx] <= fetched;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ent  <= '0;
      held_ent <= '0;
    end else begin
      if (fetch_now) begin
        cur_ent <= first_row ? fetched : stored;
      end
      if (phase == LOAD_PHASE) begin
        held_ent <= cur_ent;
      end
    end
  end

  assign cur_code = cur_ent[CODE_W-1:0];
  assign held_scr = held_ent[CODE_W-1:0];
  assign held_col = held_ent[ENT_W-1:CODE_W];

  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_now && first_row) |=> (cur_ent == $past(fetched)));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != LOAD_PHASE) |=> $stable(held_ent));

  p_hold_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LOAD_PHASE) |=> (held_ent == $past(cur_ent)));
endmodule

// File: rtl/pix_shifter.sv
module pix_shifter
  import cps_pkg::*;
#(
  parameter int PAT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic               mc_mode,
  input  logic [PAT_W-1:0]   pat_data,
  output logic [1:0]         top_pair
);
  logic [PAT_W-1:0] sr;
  logic             load_now;

  assign load_now = (phase == LOAD_PHASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load_now) begin
      sr <= pat_data;
    end else if (mc_mode) begin
      if (phase[0]) begin
        sr <= {sr[PAT_W-3:0], 2'b00};
      end
    end else begin
      sr <= {sr[PAT_W-2:0], 1'b0};
    end
  end

  assign top_pair = sr[PAT_W-1:PAT_W-2];

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (sr == $past(pat_data)));

  p_mc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_mode && !phase[0]) |=> $stable(sr));

  p_mc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_mode && phase[0] && !load_now) |=>
      ((sr[PAT_W-1:2] == $past(sr[PAT_W-3:0])) && (sr[1:0] == 2'b00)));

  p_hires_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_mode && !load_now) |=>
      ((sr[PAT_W-1:1] == $past(sr[PAT_W-2:0])) && !sr[0]));
endmodule

// File: rtl/pat_addr_gen.sv
module pat_addr_gen #(
  parameter int PBASE_W  = 3,
  parameter int CODE_W   = 8,
  parameter int ROW_W    = 3,
  parameter int SCRPOS_W = PBASE_W - 1 + CODE_W,
  parameter int ADDR_W   = PBASE_W + CODE_W + ROW_W
) (
  input  logic                bmp_mode,
  input  logic [PBASE_W-1:0]  pat_base,
  input  logic [SCRPOS_W-1:0] scr_pos,
  input  logic [CODE_W-1:0]   cur_code,
  input  logic [ROW_W-1:0]    row_in_cell,
  output logic [ADDR_W-1:0]   pat_addr
);
  logic [ADDR_W-1:0] bmp_addr;
  logic [ADDR_W-1:0] txt_addr;

  assign bmp_addr = {pat_base[PBASE_W-1], scr_pos, row_in_cell};
  assign txt_addr = {pat_base, cur_code, row_in_cell};
  assign pat_addr = bmp_mode ? bmp_addr : txt_addr;
endmodule

// File: rtl/colour_map.sv
module colour_map
  import cps_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [1:0]        top_pair,
  input  logic              mc_mode,
  input  logic [CODE_W-1:0] held_scr,
  input  colour_t           held_col,
  input  colour_t           bg_col,
  output colour_t           pix_col
);
  localparam int HALF = CODE_W / 2;

  always_comb begin
    if (mc_mode) begin
      unique case (pair_e'(top_pair))
        PAIR_BACK:  pix_col = bg_col;
        PAIR_SCR_H: pix_col = colour_t'(held_scr[CODE_W-1:HALF]);
        PAIR_SCR_L: pix_col = colour_t'(held_scr[HALF-1:0]);
        default:    pix_col = held_col;
      endcase
    end else begin
      pix_col = top_pair[1] ? held_col : bg_col;
    end
  end
endmodule

// File: rtl/cell_pixel_serializer.sv
module cell_pixel_serializer
  import cps_pkg::*;
#(
  parameter int N_COLS  = 40,
  parameter int PBASE_W = 3,
  parameter int CODE_W  = 8,
  parameter int ROW_W   = 3,
  localparam int IDX_W    = $clog2(N_COLS),
  localparam int SCRPOS_W = PBASE_W - 1 + CODE_W,
  localparam int ADDR_W   = PBASE_W + CODE_W + ROW_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PHASE_W-1:0]  phase,
  input  logic                bmp_mode,
  input  logic                mc_mode,
  input  logic [PBASE_W-1:0]  pat_base,
  input  logic [SCRPOS_W-1:0] scr_pos,
  input  logic [ROW_W-1:0]    row_in_cell,
  input  logic [IDX_W-1:0]    cell_idx,
  input  logic [CODE_W-1:0]   scr_data,
  input  logic [COLOUR_W-1:0] col_data,
  output logic [ADDR_W-1:0]   pat_addr,
  input  logic [CODE_W-1:0]   pat_data,
  input  logic [COLOUR_W-1:0] bg_col,
  output logic [COLOUR_W-1:0] pix_col
);
  logic [CODE_W-1:0] cur_code;
  logic [CODE_W-1:0] held_scr;
  colour_t           held_col;
  logic [1:0]        top_pair;

  cell_attr_buf #(
    .N_COLS(N_COLS), .IDX_W(IDX_W), .CODE_W(CODE_W), .ROW_W(ROW_W)
  ) u_attr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .row_in_cell(row_in_cell),
    .cell_idx(cell_idx), .scr_data(scr_data), .col_data(col_data),
    .cur_code(cur_code), .held_scr(held_scr), .held_col(held_col)
  );

  pat_addr_gen #(
    .PBASE_W(PBASE_W), .CODE_W(CODE_W), .ROW_W(ROW_W)
  ) u_addr (
    .bmp_mode(bmp_mode), .pat_base(pat_base), .scr_pos(scr_pos),
    .cur_code(cur_code), .row_in_cell(row_in_cell), .pat_addr(pat_addr)
  );

  pix_shifter #(.PAT_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .phase(phase), .mc_mode(mc_mode),
    .pat_data(pat_data), .top_pair(top_pair)
  );

  colour_map #(.CODE_W(CODE_W)) u_map (
    .top_pair(top_pair), .mc_mode(mc_mode), .held_scr(held_scr),
    .held_col(held_col), .bg_col(bg_col), .pix_col(pix_col)
  );

  p_mc_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_mode && (top_pair == 2'b00)) |-> (pix_col == bg_col));

  p_hires_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_mode && !top_pair[1]) |-> (pix_col == bg_col));
endmodule

// File: tb/cell_pixel_serializer_bench.sv
module cell_pixel_serializer_bench;
  localparam int NC = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  phase;
  logic        bmp_mode, mc_mode;
  logic [2:0]  pat_base;
  logic [9:0]  scr_pos;
  logic [2:0]  row_in_cell;
  logic [5:0]  cell_idx;
  logic [7:0]  scr_data;
  logic [3:0]  col_data;
  logic [13:0] pat_addr;
  logic [7:0]  pat_data;
  logic [3:0]  bg_col;
  logic [3:0]  pix_col;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cell_pixel_serializer u_cell_pixel_serializer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .bmp_mode(bmp_mode),
    .mc_mode(mc_mode), .pat_base(pat_base), .scr_pos(scr_pos),
    .row_in_cell(row_in_cell), .cell_idx(cell_idx), .scr_data(scr_data),
    .col_data(col_data), .pat_addr(pat_addr), .pat_data(pat_data),
    .bg_col(bg_col), .pix_col(pix_col)
  );

  // Behavioural reference: per-column attribute memory, current and shown attributes, pixel bits
  int m_line [NC];
  int m_cur, m_show, m_bits;

  initial begin
    for (int i = 0; i < NC; i++) m_line[i] = 0;
    m_cur = 0; m_show = 0; m_bits = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 0; m_show = 0; m_bits = 0;
    end else begin
      if (phase == 3) begin
        if (row_in_cell == 0) begin
          m_line[cell_idx] = col_data * 256 + scr_data;
          m_cur = m_line[cell_idx];
        end else begin
          m_cur = m_line[cell_idx];
        end
      end
      if (phase == 7) begin
        m_bits = pat_data;
        m_show = m_cur;
      end else if (mc_mode) begin
        if (phase % 2 == 1) m_bits = (m_bits * 4) % 256;
      end else begin
        m_bits = (m_bits * 2) % 256;
      end
    end
  end

  function automatic int exp_pix();
    int pr, scr, cram;
    pr   = m_bits / 64;
    scr  = m_show % 256;
    cram = m_show / 256;
    if (mc_mode) begin
      case (pr)
        0: return bg_col;
        1: return scr / 16;
        2: return scr % 16;
        default: return cram;
      endcase
    end
    return (pr >= 2) ? cram : int'(bg_col);
  endfunction

  function automatic int exp_addr();
    if (bmp_mode) return (pat_base / 4) * 8192 + scr_pos * 8 + row_in_cell;
    return pat_base * 2048 + (m_cur % 256) * 8 + row_in_cell;
  endfunction

  task automatic compare();
    int e;
    e = exp_pix();
    n_run++;
    if (int'(pix_col) != e) begin
      n_fail++;
      if (mc_mode) $display("FAIL R2 R4 R5 R6 pix_col actual %0h expected %0h", pix_col, e);
      else         $display("FAIL R2 R3 R6 pix_col actual %0h expected %0h", pix_col, e);
    end
    e = exp_addr();
    n_run++;
    if (int'(pat_addr) != e) begin
      n_fail++;
      if (bmp_mode) $display("FAIL R7 pat_addr actual %0h expected %0h", pat_addr, e);
      else          $display("FAIL R8 R9 pat_addr actual %0h expected %0h", pat_addr, e);
    end
  endtask

  // One pass over n_rows pixel rows of a full line of cells
  task automatic run_pass(input logic mc, input logic bmp, input logic [2:0] pb, input int n_rows);
    for (int r = 0; r < n_rows; r++) begin
      for (int c = 0; c < NC; c++) begin
        for (int p = 0; p < 8; p++) begin
          @(negedge clk);
          if (rst_n) compare();
          mc_mode     = mc;
          bmp_mode    = bmp;
          pat_base    = pb;
          phase       = 3'(p);
          row_in_cell = 3'(r % 8);
          cell_idx    = 6'(c);
          scr_pos     = 10'((r / 8) * NC + c);
          scr_data    = 8'($urandom);   // on rows other than 0 this must be ignored (R9)
          col_data    = 4'($urandom);
          pat_data    = 8'($urandom);
          if (p == 0) bg_col = 4'($urandom);
        end
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; phase = 3'd0; bmp_mode = 1'b0; mc_mode = 1'b0;
    pat_base = 3'd0; scr_pos = '0; row_in_cell = '0; cell_idx = '0;
    scr_data = 8'hff; col_data = 4'hf; pat_data = 8'hff; bg_col = 4'h5;
    repeat (3) @(negedge clk);
    // R1: reset clears the pattern and attributes, so the background shows
    n_run++;
    if (pix_col != 4'h5) begin
      n_fail++;
      $display("FAIL R1 pix_col in reset actual %0h expected 5", pix_col);
    end
    mc_mode = 1'b1;
    @(negedge clk);
    n_run++;
    if (pix_col != 4'h5) begin
      n_fail++;
      $display("FAIL R1 multicolor pix_col in reset actual %0h expected 5", pix_col);
    end
    rst_n = 1'b1;
    run_pass(1'b0, 1'b0, 3'd5, 16);  // hi-res text, R3 R8 R9
    run_pass(1'b1, 1'b1, 3'd6, 8);   // multicolor bitmap, R4 R5 R7
    run_pass(1'b0, 1'b1, 3'd3, 8);   // hi-res bitmap, R3 R7
    run_pass(1'b1, 1'b0, 3'd2, 8);   // multicolor text, R4 R5 R8 R9
    @(negedge clk);
    compare();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule